// File: doc/BRIEF.md
# Memory ECC Error Injection Unit

This unit sits in the write path of a memory controller, between the ECC encoder and the memory. It exists to corrupt stored data on purpose, so that the detection and correction logic further down the path can be tested. Each write that passes through carries its location: dimm within its channel, rank, channel, bank, page and column. It also carries a codeword made of two data halves with one parity bit per half. The codeword leaves the unit one clock later. It is either unchanged or has chosen bits inverted.

Software sets up the unit through a small register port. It programs a location filter in which each of the six fields either compares or matches anything. It also programs a mask of bit positions, a section code that picks which half or halves are hit, and a kind field (repeat, data flip, parity flip). Finally it arms the unit through an enable register. In one-shot mode the unit disarms itself after the first write it corrupts. In repeat mode it keeps corrupting matching writes until software disarms it.

Top module: `ecc_inject_unit`

## Requirements
- R1: Every write accepted on `wr_valid` appears on `out_valid` exactly one clock later. When no injection fires, its data and parity bits are unchanged.
- R2: Registers 0 to 5 are the location filter fields (dimm, rank, channel, bank, page, column). Bit 31 of each is a compare flag and the low bits hold the value. A write hits only if every field with its flag set equals the write's field. A field whose flag is 0 matches anything.
- R3: After reset all compare flags are 0 (every field matches anything), and mask, section, kind and enable all read 0.
- R4: Register 6 is the mask. When kind bit 1 is set, each selected data half is XORed with the mask.
- R5: Register 7 is the section code (2 bits). Value 1 selects the lower half (data bits 31:0, parity bit 0), 2 the upper half (data bits 63:32, parity bit 1), and 3 both halves.
- R6: Register 8 is the kind field. Bit 0 is repeat, bit 1 is a data flip, bit 2 is a parity flip. With bit 2 set, the parity bit of each selected half is inverted.
- R7: Register 9 is the enable. Writing any nonzero value arms the unit, writing 0 disarms it, and it reads back as 1 or 0.
- R8: With repeat clear, the enable reads 0 after the first corrupted write, and the next matching write passes clean. With repeat set, every matching write is corrupted.
- R9: Every register reads back what was stored: a field as {flag, 0s, value masked to the field width}, and the others zero-extended. Unused addresses read 0.
- R10: `out_inj` is 1 exactly for the outputs that an injection altered, and only while the unit was armed.
- R11: If the section is 0, or neither kind bit 1 nor kind bit 2 is set, no bit is altered even when the unit is armed and the location hits, and the enable stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| wr_valid | input | 1 | A write codeword is present |
| wr_dimm | input | 2 | Dimm number within its channel |
| wr_rank | input | 2 | Rank |
| wr_chan | input | 2 | Channel |
| wr_bank | input | 3 | Bank |
| wr_page | input | 16 | Page (row) address |
| wr_col | input | 12 | Column address |
| wr_data | input | 64 | Data bits of the codeword |
| wr_par | input | 2 | One parity bit per half |
| out_valid | output | 1 | Registered codeword present |
| out_data | output | 64 | Data bits, possibly corrupted |
| out_par | output | 2 | Parity bits, possibly corrupted |
| out_inj | output | 1 | This codeword was corrupted |

## Verification
The hardest case to reach is a one-shot injection followed directly by a second matching write on the next clock. The disarm has to take effect in the same edge that registers the corrupted word, so that the second word leaves clean. The stimulus arms the unit in one-shot mode and drives two matching writes back to back with no idle cycle between them. It then reads the enable back. A second sequence stacks several compare flags and changes one field at a time, so that a single mismatching field blocks the hit. It then clears a flag and shows that the same write now hits.

// File: rtl/einj_pkg.sv
package einj_pkg;

   localparam int NUM_FLD  = 6;
   localparam int NUM_HALF = 2;
   localparam int ADDR_W   = 4;

   typedef enum logic [ADDR_W-1:0] {
      RA_DIMM = 4'd0,
      RA_RANK = 4'd1,
      RA_CHAN = 4'd2,
      RA_BANK = 4'd3,
      RA_PAGE = 4'd4,
      RA_COL  = 4'd5,
      RA_MASK = 4'd6,
      RA_SECT = 4'd7,
      RA_KIND = 4'd8,
      RA_ARM  = 4'd9
   } reg_addr_e;

   localparam int KB_REP  = 0;
   localparam int KB_DATA = 1;
   localparam int KB_PAR  = 2;
   localparam int KIND_W  = 3;

endpackage

// File: rtl/einj_regs.sv
module einj_regs
   import einj_pkg::*;
#(
   parameter int REG_W  = 32,
   parameter int HALF_W = 32,
   parameter int DIMM_W = 2,
   parameter int RANK_W = 2,
   parameter int CHAN_W = 2,
   parameter int BANK_W = 3,
   parameter int PAGE_W = 16,
   parameter int COL_W  = 12,
   localparam int VAL_W = REG_W - 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cfg_wr,
   input  logic [ADDR_W-1:0]                cfg_addr,
   input  logic [REG_W-1:0]                 cfg_wdata,
   output logic [REG_W-1:0]                 cfg_rdata,
   input  logic                             fire,
   output logic [NUM_FLD-1:0]               fld_cmp,
   output logic [NUM_FLD-1:0][VAL_W-1:0]    fld_val,
   output logic [HALF_W-1:0]                mask_q,
   output logic [NUM_HALF-1:0]              sect_q,
   output logic [KIND_W-1:0]                kind_q,
   output logic                             arm_q
);

   localparam int FW [NUM_FLD] = '{DIMM_W, RANK_W, CHAN_W, BANK_W, PAGE_W, COL_W};

   for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
      localparam logic [VAL_W-1:0] FMSK = {VAL_W{1'b1}} >> (VAL_W - FW[g]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fld_cmp[g] <= 1'b0;
            fld_val[g] <= '0;
         end else if (cfg_wr && cfg_addr == ADDR_W'(g)) begin
            fld_cmp[g] <= cfg_wdata[REG_W-1];
            fld_val[g] <= cfg_wdata[VAL_W-1:0] & FMSK;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         sect_q <= '0;
         kind_q <= '0;
         arm_q  <= 1'b0;
      end else begin
         if (fire && !kind_q[KB_REP]) arm_q <= 1'b0;
         if (cfg_wr) begin
            case (cfg_addr)
               RA_MASK: mask_q <= cfg_wdata[HALF_W-1:0];
               RA_SECT: sect_q <= cfg_wdata[NUM_HALF-1:0];
               RA_KIND: kind_q <= cfg_wdata[KIND_W-1:0];
               RA_ARM:  arm_q  <= |cfg_wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      for (int i = 0; i < NUM_FLD; i++) begin
         if (cfg_addr == ADDR_W'(i)) cfg_rdata = {fld_cmp[i], fld_val[i]};
      end
      case (cfg_addr)
         RA_MASK: cfg_rdata = REG_W'(mask_q);
         RA_SECT: cfg_rdata = REG_W'(sect_q);
         RA_KIND: cfg_rdata = REG_W'(kind_q);
         RA_ARM:  cfg_rdata = REG_W'(arm_q);
         default: ;
      endcase
   end

endmodule

// File: rtl/einj_match.sv
module einj_match
   import einj_pkg::*;
#(
   parameter int VAL_W = 31
) (
   input  logic [NUM_FLD-1:0]            fld_cmp,
   input  logic [NUM_FLD-1:0][VAL_W-1:0] fld_val,
   input  logic [NUM_FLD-1:0][VAL_W-1:0] req_val,
   output logic                          hit
);

   logic [NUM_FLD-1:0] fld_ok;

   for (genvar g = 0; g < NUM_FLD; g++) begin : g_cmp
      assign fld_ok[g] = !fld_cmp[g] || (fld_val[g] == req_val[g]);
   end

   assign hit = &fld_ok;

endmodule

// File: rtl/einj_corrupt.sv
module einj_corrupt
   import einj_pkg::*;
#(
   parameter int HALF_W = 32,
   localparam int WORD_W = NUM_HALF * HALF_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 fire,
   input  logic [NUM_HALF-1:0]  sect,
   input  logic [KIND_W-1:0]    kind,
   input  logic [HALF_W-1:0]    mask,
   input  logic [WORD_W-1:0]    in_data,
   input  logic [NUM_HALF-1:0]  in_par,
   output logic                 out_valid,
   output logic [WORD_W-1:0]    out_data,
   output logic [NUM_HALF-1:0]  out_par,
   output logic                 out_inj
);

   logic [WORD_W-1:0]   nxt_data;
   logic [NUM_HALF-1:0] nxt_par;

   for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
      logic hit_h;
      assign hit_h = fire && sect[h];
      assign nxt_data[h*HALF_W +: HALF_W] = in_data[h*HALF_W +: HALF_W]
                                          ^ ((hit_h && kind[KB_DATA]) ? mask : '0);
      assign nxt_par[h] = in_par[h] ^ (hit_h && kind[KB_PAR]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_par   <= '0;
         out_inj   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_inj   <= fire;
         if (in_valid) begin
            out_data <= nxt_data;
            out_par  <= nxt_par;
         end
      end
   end

endmodule

// File: rtl/ecc_inject_unit.sv
module ecc_inject_unit
   import einj_pkg::*;
#(
   parameter int REG_W  = 32,
   parameter int HALF_W = 32,
   parameter int DIMM_W = 2,
   parameter int RANK_W = 2,
   parameter int CHAN_W = 2,
   parameter int BANK_W = 3,
   parameter int PAGE_W = 16,
   parameter int COL_W  = 12,
   localparam int VAL_W  = REG_W - 1,
   localparam int WORD_W = NUM_HALF * HALF_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr,
   input  logic [ADDR_W-1:0]   cfg_addr,
   input  logic [REG_W-1:0]    cfg_wdata,
   output logic [REG_W-1:0]    cfg_rdata,
   input  logic                wr_valid,
   input  logic [DIMM_W-1:0]   wr_dimm,
   input  logic [RANK_W-1:0]   wr_rank,
   input  logic [CHAN_W-1:0]   wr_chan,
   input  logic [BANK_W-1:0]   wr_bank,
   input  logic [PAGE_W-1:0]   wr_page,
   input  logic [COL_W-1:0]    wr_col,
   input  logic [WORD_W-1:0]   wr_data,
   input  logic [NUM_HALF-1:0] wr_par,
   output logic                out_valid,
   output logic [WORD_W-1:0]   out_data,
   output logic [NUM_HALF-1:0] out_par,
   output logic                out_inj
);

   if (HALF_W > REG_W) begin : g_bad_half
      $error("HALF_W must fit in one register");
   end
   if (DIMM_W > VAL_W || RANK_W > VAL_W || CHAN_W > VAL_W ||
       BANK_W > VAL_W || PAGE_W > VAL_W || COL_W > VAL_W) begin : g_bad_fld
      $error("a location field is wider than a register value");
   end

   logic [NUM_FLD-1:0]            fld_cmp;
   logic [NUM_FLD-1:0][VAL_W-1:0] fld_val;
   logic [NUM_FLD-1:0][VAL_W-1:0] req_val;
   logic [HALF_W-1:0]             mask_q;
   logic [NUM_HALF-1:0]           sect_q;
   logic [KIND_W-1:0]             kind_q;
   logic                          arm_q;
   logic                          loc_hit;
   logic                          fire;

   assign req_val[RA_DIMM] = VAL_W'(wr_dimm);
   assign req_val[RA_RANK] = VAL_W'(wr_rank);
   assign req_val[RA_CHAN] = VAL_W'(wr_chan);
   assign req_val[RA_BANK] = VAL_W'(wr_bank);
   assign req_val[RA_PAGE] = VAL_W'(wr_page);
   assign req_val[RA_COL]  = VAL_W'(wr_col);

   einj_regs #(
      .REG_W(REG_W), .HALF_W(HALF_W), .DIMM_W(DIMM_W), .RANK_W(RANK_W),
      .CHAN_W(CHAN_W), .BANK_W(BANK_W), .PAGE_W(PAGE_W), .COL_W(COL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fire(fire),
      .fld_cmp(fld_cmp), .fld_val(fld_val), .mask_q(mask_q),
      .sect_q(sect_q), .kind_q(kind_q), .arm_q(arm_q)
   );

   einj_match #(.VAL_W(VAL_W)) u_match (
      .fld_cmp(fld_cmp), .fld_val(fld_val), .req_val(req_val), .hit(loc_hit)
   );

   assign fire = wr_valid && arm_q && loc_hit && (|sect_q)
               && (kind_q[KB_DATA] || kind_q[KB_PAR]);

   einj_corrupt #(.HALF_W(HALF_W)) u_corrupt (
      .clk(clk), .rst_n(rst_n), .in_valid(wr_valid), .fire(fire),
      .sect(sect_q), .kind(kind_q), .mask(mask_q), .in_data(wr_data),
      .in_par(wr_par), .out_valid(out_valid), .out_data(out_data),
      .out_par(out_par), .out_inj(out_inj)
   );

endmodule

// File: rtl/einj_chk.sv
module einj_chk
   import einj_pkg::*;
#(
   parameter int HALF_W = 32,
   localparam int WORD_W = NUM_HALF * HALF_W
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_wr,
   input logic [ADDR_W-1:0]   cfg_addr,
   input logic                wr_valid,
   input logic [WORD_W-1:0]   wr_data,
   input logic [NUM_HALF-1:0] wr_par,
   input logic                out_valid,
   input logic [WORD_W-1:0]   out_data,
   input logic [NUM_HALF-1:0] out_par,
   input logic                out_inj,
   input logic                arm_q,
   input logic [KIND_W-1:0]   kind_q,
   input logic [NUM_HALF-1:0] sect_q
);

   assert_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> out_valid);

   assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |=> !out_valid);

   assert_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_inj) |-> (out_data == $past(wr_data) && out_par == $past(wr_par)));

   assert_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_inj |-> out_valid);

   assert_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_inj |-> $past(arm_q));

   assert_oneshot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_inj && $past(!kind_q[KB_REP] && !(cfg_wr && cfg_addr == RA_ARM))) |-> !arm_q);

   assert_nokind_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(sect_q == '0 || kind_q[KB_PAR:KB_DATA] == '0)) |-> !out_inj);

   assert_parflip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_inj && $past(kind_q[KB_PAR])) |-> (out_par != $past(wr_par)));

endmodule

bind ecc_inject_unit einj_chk #(.HALF_W(HALF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
   .wr_valid(wr_valid), .wr_data(wr_data), .wr_par(wr_par),
   .out_valid(out_valid), .out_data(out_data), .out_par(out_par),
   .out_inj(out_inj), .arm_q(arm_q), .kind_q(kind_q), .sect_q(sect_q)
);

// File: tb/ecc_inject_unit_tb.sv
module ecc_inject_unit_tb;

   typedef struct packed {
      logic [63:0] d;
      logic [1:0]  p;
      logic        inj;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        wr_valid = 1'b0;
   logic [1:0]  wr_dimm = '0, wr_rank = '0, wr_chan = '0;
   logic [2:0]  wr_bank = '0;
   logic [15:0] wr_page = '0;
   logic [11:0] wr_col = '0;
   logic [63:0] wr_data = '0;
   logic [1:0]  wr_par = '0;
   logic        out_valid;
   logic [63:0] out_data;
   logic [1:0]  out_par;
   logic        out_inj;

   int checks = 0;
   int errors = 0;
   exp_t sb[$];

   logic        m_cmp [6];
   logic [30:0] m_val [6];
   logic [31:0] m_mask;
   logic [1:0]  m_sect;
   logic [2:0]  m_kind;
   logic        m_arm;

   always #4 clk = ~clk;

   ecc_inject_unit u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wr_valid(wr_valid),
      .wr_dimm(wr_dimm), .wr_rank(wr_rank), .wr_chan(wr_chan),
      .wr_bank(wr_bank), .wr_page(wr_page), .wr_col(wr_col),
      .wr_data(wr_data), .wr_par(wr_par), .out_valid(out_valid),
      .out_data(out_data), .out_par(out_par), .out_inj(out_inj)
   );

   task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(logic [3:0] a, logic [31:0] v);
      @(negedge clk);
      wr_valid = 1'b0;
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = v;
      if (a < 4'd6) begin
         m_cmp[a] = v[31];
         case (a)
            4'd0, 4'd1, 4'd2: m_val[a] = 31'(v[1:0]);
            4'd3: m_val[a] = 31'(v[2:0]);
            4'd4: m_val[a] = 31'(v[15:0]);
            default: m_val[a] = 31'(v[11:0]);
         endcase
      end
      else if (a == 4'd6) m_mask = v;
      else if (a == 4'd7) m_sect = v[1:0];
      else if (a == 4'd8) m_kind = v[2:0];
      else if (a == 4'd9) m_arm = |v;
   endtask

   task automatic send_wr(int dm, int rk, int ch, int bk, int pg, int cl,
                          logic [63:0] d, logic [1:0] p);
      logic hit;
      logic fire;
      int   req [6];
      exp_t e;
      @(negedge clk);
      cfg_wr = 1'b0;
      wr_valid = 1'b1;
      wr_dimm = 2'(dm); wr_rank = 2'(rk); wr_chan = 2'(ch);
      wr_bank = 3'(bk); wr_page = 16'(pg); wr_col = 12'(cl);
      wr_data = d; wr_par = p;
      req = '{dm, rk, ch, bk, pg, cl};
      hit = 1'b1;
      for (int i = 0; i < 6; i++)
         if (m_cmp[i] && m_val[i] != 31'(req[i])) hit = 1'b0;
      fire = m_arm && hit && (m_sect != 2'b00) && (m_kind[1] || m_kind[2]);
      e.d = d; e.p = p; e.inj = fire;
      if (fire) begin
         for (int h = 0; h < 2; h++) begin
            if (m_sect[h]) begin
               if (m_kind[1]) e.d[h*32 +: 32] = e.d[h*32 +: 32] ^ m_mask;
               if (m_kind[2]) e.p[h] = ~e.p[h];
            end
         end
         if (!m_kind[0]) m_arm = 1'b0;
      end
      sb.push_back(e);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cfg_wr = 1'b0;
         wr_valid = 1'b0;
      end
   endtask

   task automatic cfg_read(logic [3:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      cfg_wr = 1'b0; wr_valid = 1'b0; cfg_addr = a;
      #1;
      check(tag, 128'(cfg_rdata), 128'(exp));
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            check("R1 unexpected output", 128'(1), 128'(0));
         end else begin
            exp_t e;
            e = sb.pop_front();
            check("R1/R4/R5/R6 codeword", {62'(0), out_data, out_par}, {62'(0), e.d, e.p});
            check("R10 inject flag", 128'(out_inj), 128'(e.inj));
         end
      end
   end

   initial begin
      #(8 * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 6; i++) begin m_cmp[i] = 1'b0; m_val[i] = '0; end
      m_mask = '0; m_sect = '0; m_kind = '0; m_arm = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R3 reset state
      check("R3 out_valid after reset", 128'(out_valid), 128'(0));
      for (int i = 0; i < 10; i++) cfg_read(4'(i), 32'h0, "R3 register reset value");

      // R1 pass-through while disarmed
      send_wr(1, 1, 1, 1, 100, 7, 64'h0123_4567_89ab_cdef, 2'b10);
      send_wr(0, 0, 0, 0, 0, 0, 64'hffff_0000_ffff_0000, 2'b01);
      idle(2);

      // R4 R5 R6 repeat mode, wildcard location, both halves, data flip
      cfg_write(4'd6, 32'h0000_0040);
      cfg_write(4'd7, 32'd3);
      cfg_write(4'd8, 32'b011);
      cfg_write(4'd9, 32'd5);
      cfg_read(4'd9, 32'd1, "R7 nonzero write arms");
      send_wr(2, 3, 0, 5, 9, 9, 64'h1111_2222_3333_4444, 2'b00);
      send_wr(1, 0, 3, 2, 1, 4, 64'h0, 2'b11);
      idle(2);
      cfg_read(4'd9, 32'd1, "R8 repeat keeps enable");

      // R2 channel filter
      cfg_write(4'd2, 32'h8000_0002);
      send_wr(0, 0, 1, 0, 0, 0, 64'hdead_beef_dead_beef, 2'b00);
      send_wr(0, 0, 2, 0, 0, 0, 64'hdead_beef_dead_beef, 2'b00);
      idle(2);

      // R2 several fields, one mismatching field blocks
      cfg_write(4'd0, 32'h8000_0002);
      cfg_write(4'd1, 32'h8000_0001);
      cfg_write(4'd4, 32'h8000_1234);
      send_wr(2, 1, 2, 7, 16'h1234, 3, 64'haaaa_aaaa_5555_5555, 2'b01);
      send_wr(2, 0, 2, 7, 16'h1234, 3, 64'haaaa_aaaa_5555_5555, 2'b01);
      send_wr(2, 1, 2, 7, 16'h1235, 3, 64'haaaa_aaaa_5555_5555, 2'b01);
      idle(2);

      // R9 readback of stored fields and masked value
      cfg_write(4'd5, 32'h8000_ffff);
      cfg_read(4'd5, 32'h8000_0fff, "R9 column masked to width");
      cfg_read(4'd4, 32'h8000_1234, "R9 page readback");
      cfg_read(4'd6, 32'h0000_0040, "R9 mask readback");
      cfg_read(4'd8, 32'd3, "R9 kind readback");
      cfg_read(4'd12, 32'h0, "R9 unused address");

      // R2 clearing flags restores match-anything
      for (int i = 0; i < 6; i++) cfg_write(4'(i), 32'h0);
      cfg_read(4'd2, 32'h0, "R2 flag cleared");
      send_wr(3, 3, 3, 7, 500, 99, 64'h0f0f_0f0f_0f0f_0f0f, 2'b10);
      idle(2);

      // R8 one-shot, back-to-back matching writes
      cfg_write(4'd8, 32'b110);
      cfg_write(4'd7, 32'd1);
      cfg_write(4'd6, 32'h8000_0001);
      cfg_write(4'd9, 32'd1);
      send_wr(0, 0, 0, 0, 0, 0, 64'h0, 2'b00);
      send_wr(0, 0, 0, 0, 0, 0, 64'h0, 2'b00);
      idle(2);
      cfg_read(4'd9, 32'd0, "R8 one-shot disarms");

      // R5 upper half only, parity only
      cfg_write(4'd7, 32'd2);
      cfg_write(4'd8, 32'b100);
      cfg_write(4'd9, 32'hffff_ffff);
      send_wr(1, 1, 1, 1, 1, 1, 64'h1234_5678_9abc_def0, 2'b01);
      idle(2);
      cfg_read(4'd9, 32'd0, "R8 one-shot after parity hit");

      // R11 section zero and kind without data/parity bit
      cfg_write(4'd7, 32'd0);
      cfg_write(4'd8, 32'b111);
      cfg_write(4'd9, 32'd1);
      send_wr(0, 0, 0, 0, 0, 0, 64'h5555_5555_5555_5555, 2'b11);
      idle(2);
      cfg_read(4'd9, 32'd1, "R11 section zero keeps enable");
      cfg_write(4'd7, 32'd3);
      cfg_write(4'd8, 32'b001);
      send_wr(0, 0, 0, 0, 0, 0, 64'h5555_5555_5555_5555, 2'b11);
      idle(2);
      cfg_read(4'd9, 32'd1, "R11 repeat-only kind keeps enable");

      // R7 zero write disarms
      cfg_write(4'd8, 32'b011);
      cfg_write(4'd9, 32'd0);
      cfg_read(4'd9, 32'd0, "R7 zero write disarms");
      send_wr(0, 0, 0, 0, 0, 0, 64'h7777_7777_7777_7777, 2'b00);
      idle(3);

      check("R1 scoreboard drained", 128'(sb.size()), 128'(0));
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule